// File: doc/BRIEF.md
# Peripheral clock-stop and reset register block

This block is a small memory-mapped register file that controls 64 peripheral reset lines and 64 peripheral clock-stop controls. Each group of 64 controls is held in two 32-bit words. Software never needs a read-modify-write. Every word has two byte addresses. A write to the base address raises each bit written as one. A write to the address one word above it lowers each bit written as one. In both cases, bits written as zero keep their value.

The reset words drive a reset line per peripheral, where one means held in reset. The clock-stop words drive a clock-enable line per peripheral. For most bits, a stored one means the clock is stopped. Bit 14 of the low clock word uses the opposite sense, so a stored one enables that clock. Bit 31 of the low clock word also acts as a plain option bit that selects a divide-by-13 mode for a shared serial-port reference clock. Reads return the raw stored words on a combinational read-data path. Both alias addresses of a word return the same value.

Top module: `clkrst_regs`

## Requirements
- R1: After reset:
  - every reset line is high;
  - every clock enable is low;
  - `uartDiv13` is high;
  - the reset words read 0xFFFFFFFF;
  - the low clock word reads 0xFFFFBFFF;
  - the high clock word reads 0xFFFFFFFF.
- R2: A write to a word's base address (0x040, 0x050, 0x080 or 0x090) sets every bit whose data bit is one and leaves the other bits unchanged.
- R3: A write to a word's clear alias (base + 4: 0x044, 0x054, 0x084 or 0x094) clears every bit whose data bit is one and leaves the other bits unchanged.
- R4: Control line n lives in the low word of its group (0x040 for reset, 0x080 for clock) at bit n when n < 32. It lives in the high word (0x050 or 0x090) at bit n-32 when n ≥ 32. It drives `rstLines[n]` or `clkEnable[n]`.
- R5: `rstLines[n]` equals the stored reset bit for line n, so one holds that peripheral in reset.
- R6: `clkEnable[n]` is the inverse of the stored clock-stop bit for every line except line 14, where `clkEnable[14]` equals the stored bit.
- R7: Bit 31 of the word at 0x080 reads back as written and drives `uartDiv13`.
- R8: A read at a clear-alias address returns the same value as a read at its base address.
- R9: The outputs are registered. They take their new value at the clock edge that accepts the write, not before it. They do not change in a cycle without a write.
- R10: A write to any other address changes nothing, and a read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data, used as a set or clear mask |
| busRdData | output | 32 | Stored word at `busAddr`, zero if unmapped |
| rstLines | output | 64 | Per-peripheral reset, high = held in reset |
| clkEnable | output | 64 | Per-peripheral clock enable, high = running |
| uartDiv13 | output | 1 | Divide-by-13 option for the shared serial reference |

## Verification
The bench walks a single cleared bit and a single set bit across all 64 lines of both groups. This catches a line steered into the wrong word or bit, and an inversion missing or misplaced on line 14, which would leave that clock running out of reset or stopped when software enabled it. A long pseudo-random run of set and clear writes to all eight addresses is compared against a bench model. It would expose a design that replaced the word instead of masking it, or that swapped the roles of the two aliases. The bench also writes all ones to unmapped and near-miss addresses and writes all zeros to mapped ones, to catch a loose address decode or a mask that acts on zero bits. It samples one output just before and just after the accepting edge, to catch an output that is combinational or one cycle late.

// File: rtl/clkrst_regs_pkg.sv
package clkrst_regs_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;   // 0 reset low, 1 reset high, 2 stop low, 3 stop high
  localparam int CLR_STEP  = 4;   // clear alias sits one word above the base

  localparam logic [11:0] RST_LO_OFF  = 12'h040;
  localparam logic [11:0] RST_HI_OFF  = 12'h050;
  localparam logic [11:0] STOP_LO_OFF = 12'h080;
  localparam logic [11:0] STOP_HI_OFF = 12'h090;

  // Decoded per-word strobes handed from the decoder to the datapath
  typedef struct packed {
    logic [NUM_WORDS-1:0] setStb;
    logic [NUM_WORDS-1:0] clrStb;
    logic [NUM_WORDS-1:0] rdSel;
  } regStrobe_t;

  function automatic logic [11:0] wordBase(input int k);
    case (k)
      0:       return RST_LO_OFF;
      1:       return RST_HI_OFF;
      2:       return STOP_LO_OFF;
      default: return STOP_HI_OFF;
    endcase
  endfunction

endpackage

// File: rtl/clkrst_regs_ctrl.sv
module clkrst_regs_ctrl
  import clkrst_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (busAddr == ADDR_W'(wordBase(k))) begin
        strobe.rdSel[k]  = 1'b1;
        strobe.setStb[k] = busWrEn;
      end
      if (busAddr == ADDR_W'(wordBase(k) + 12'(CLR_STEP))) begin
        strobe.rdSel[k]  = 1'b1;
        strobe.clrStb[k] = busWrEn;
      end
    end
  end

endmodule

// File: rtl/clkrst_regs_dp.sv
module clkrst_regs_dp
  import clkrst_regs_pkg::*;
#(
  parameter int INV_BIT = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   rdData,
  output logic [2*WORD_W-1:0] rstLines,
  output logic [2*WORD_W-1:0] clkEnable,
  output logic                uartDiv13
);

  localparam int LINES = 2 * WORD_W;
  localparam logic [LINES-1:0] INV_MASK = LINES'(1) << INV_BIT;
  localparam int DIV13_POS = 3 * WORD_W - 1;   // bit 31 of the low stop word

  logic [NUM_WORDS*WORD_W-1:0] curAll;
  logic [NUM_WORDS*WORD_W-1:0] nextAll;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : gWord
    // Low stop word resets with the inverted-sense bit cleared (clock disabled)
    localparam logic [WORD_W-1:0] RESET_VAL =
      (k == 2) ? ~(WORD_W'(1) << INV_BIT) : '1;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] nxt;

    // Clear is applied last, so it would win over a simultaneous set
    always_comb
      nxt = (cur | (strobe.setStb[k] ? wrData : '0))
                 & ~(strobe.clrStb[k] ? wrData : '0);

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) cur <= RESET_VAL;
      else       cur <= nxt;

    assign curAll[k*WORD_W +: WORD_W]  = cur;
    assign nextAll[k*WORD_W +: WORD_W] = nxt;
  end

  // Output flops load from the next state so they move with the word
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rstLines  <= '1;
      clkEnable <= '0;
      uartDiv13 <= 1'b1;
    end else begin
      rstLines  <= nextAll[LINES-1:0];
      clkEnable <= nextAll[2*LINES-1:LINES] ^ ~INV_MASK;
      uartDiv13 <= nextAll[DIV13_POS];
    end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (strobe.rdSel[k]) rdData = curAll[k*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/clkrst_regs.sv
module clkrst_regs
  import clkrst_regs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int INV_BIT = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [63:0]       rstLines,
  output logic [63:0]       clkEnable,
  output logic              uartDiv13
);

  regStrobe_t strobe;

  clkrst_regs_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  clkrst_regs_dp #(.INV_BIT(INV_BIT)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .rstLines  (rstLines),
    .clkEnable (clkEnable),
    .uartDiv13 (uartDiv13)
  );

endmodule

// File: rtl/clkrst_regs_chk.sv
module clkrst_regs_chk
  import clkrst_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic [63:0]       rstLines,
  input logic [63:0]       clkEnable,
  input logic              uartDiv13
);

  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (busAddr == ADDR_W'(wordBase(k)) ||
          busAddr == ADDR_W'(wordBase(k) + 12'(CLR_STEP))) mapped = 1'b1;
  end

  AST_RST_LO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(RST_LO_OFF)) |=>
      rstLines[31:0] == ($past(rstLines[31:0]) | $past(busWrData))); // R2

  AST_STOP_HI_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(STOP_HI_OFF + 12'(CLR_STEP))) |=>
      clkEnable[63:32] == ($past(clkEnable[63:32]) | $past(busWrData))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(rstLines) && $stable(clkEnable) && $stable(uartDiv13))); // R9

  AST_RST_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(RST_HI_OFF)) |-> busRdData == rstLines[63:32]); // R5

  AST_INV_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(STOP_LO_OFF)) |->
      (busRdData[14] == clkEnable[14] && busRdData[13] != clkEnable[13])); // R6

  AST_DIV13_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(STOP_LO_OFF + 12'(CLR_STEP))) |-> busRdData[31] == uartDiv13); // R7

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !mapped) |=> ($stable(rstLines) && $stable(clkEnable))); // R10

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdData == 32'h0); // R10

endmodule

bind clkrst_regs clkrst_regs_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .rstLines  (rstLines),
  .clkEnable (clkEnable),
  .uartDiv13 (uartDiv13)
);

// File: tb/clkrst_regs_test.sv
`timescale 1ns/1ps
module clkrst_regs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = 12'h000;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic [63:0] rstLines;
  logic [63:0] clkEnable;
  logic        uartDiv13;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [63:0] mRst;
  logic [63:0] mStop;
  localparam logic [63:0] INV = 64'h1 << 14;
  localparam logic [11:0] BASES [4] = '{12'h040, 12'h050, 12'h080, 12'h090};

  always #5 clk = ~clk;

  clkrst_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .rstLines(rstLines),
    .clkEnable(clkEnable), .uartDiv13(uartDiv13)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelWord(input int k);
    case (k)
      0:       return mRst[31:0];
      1:       return mRst[63:32];
      2:       return mStop[31:0];
      default: return mStop[63:32];
    endcase
  endfunction

  function automatic void modelWrite(input logic [11:0] a, input logic [31:0] d);
    for (int k = 0; k < 4; k++) begin
      logic [63:0] m;
      m = (k % 2 == 0) ? {32'h0, d} : {d, 32'h0};
      if (a == BASES[k]) begin
        if (k < 2) mRst = mRst | m; else mStop = mStop | m;
      end
      if (a == BASES[k] + 12'd4) begin
        if (k < 2) mRst = mRst & ~m; else mStop = mStop & ~m;
      end
    end
  endfunction

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 12'h000; busWrData = 32'h0;
    modelWrite(a, d);
  endtask

  task automatic checkOutputs(input string tag);
    check({tag, " rstLines R5"}, rstLines, mRst);
    check({tag, " clkEnable R6"}, clkEnable, mStop ^ ~INV);
    check({tag, " uartDiv13 R7"}, {63'h0, uartDiv13}, {63'h0, mStop[31]});
  endtask

  task automatic checkReads(input string tag);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); busAddr = BASES[k]; #1;
      check({tag, " base read R4"}, {32'h0, busRdData}, {32'h0, modelWord(k)});
      @(negedge clk); busAddr = BASES[k] + 12'd4; #1;
      check({tag, " alias read R8"}, {32'h0, busRdData}, {32'h0, modelWord(k)});
    end
    busAddr = 12'h000;
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    mRst = '1;
    mStop = ~INV;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rstLines", rstLines, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 clkEnable", clkEnable, 64'h0);
    check("R1 uartDiv13", {63'h0, uartDiv13}, 64'h1);
    @(negedge clk); busAddr = 12'h080; #1;
    check("R1 stop low read", {32'h0, busRdData}, 64'hFFFF_BFFF);
    checkReads("R1");

    // R9 latency: output holds until the accepting edge
    @(negedge clk);
    busAddr = 12'h044; busWrEn = 1'b1; busWrData = 32'h1;
    #1 check("R9 before edge", {63'h0, rstLines[0]}, 64'h1);
    @(posedge clk); #1;
    check("R9 after edge", {63'h0, rstLines[0]}, 64'h0);
    @(negedge clk); busWrEn = 1'b0; busAddr = 12'h000;
    modelWrite(12'h044, 32'h1);
    repeat (3) @(negedge clk);
    check("R9 idle hold", rstLines, mRst);
    busWrite(12'h040, 32'h1);
    checkOutputs("R9 restore");

    // R4 walking single line across both groups
    for (int n = 0; n < 64; n++) begin
      logic [31:0] bitv;
      int w;
      bitv = 32'h1 << (n % 32);
      w = n / 32;
      busWrite(BASES[w] + 12'd4, bitv);
      check("R4 rst line clear", rstLines, mRst);
      check("R3 single clear", {63'h0, rstLines[n]}, 64'h0);
      busWrite(BASES[2 + w] + 12'd4, bitv);
      check("R6 enable line", clkEnable, mStop ^ ~INV);
      check("R7 div13", {63'h0, uartDiv13}, {63'h0, mStop[31]});
      busWrite(BASES[2 + w], bitv);
      checkOutputs("R4 stop set");
      busWrite(BASES[w], bitv);
      check("R2 single set", {63'h0, rstLines[n]}, 64'h1);
    end
    checkReads("R4 walk end");

    // R2 R3 pseudo-random set/clear traffic
    seed = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      busWrite(BASES[seed[3:2]] + (seed[7] ? 12'd4 : 12'd0), seed);
      checkOutputs("R2 R3 random");
      if (i % 25 == 0) checkReads("R8 random");
    end

    // R10 unmapped writes and reads
    begin
      logic [11:0] bad [6] = '{12'h000, 12'h048, 12'h042, 12'h0C0, 12'h098, 12'h140};
      for (int j = 0; j < 6; j++) begin
        busWrite(bad[j], 32'hFFFF_FFFF);
        checkOutputs("R10 unmapped write");
        @(negedge clk); busAddr = bad[j]; #1;
        check("R10 unmapped read", {32'h0, busRdData}, 64'h0);
      end
    end

    // R2 R3 zero mask has no effect
    for (int k = 0; k < 8; k++) begin
      busWrite(BASES[k / 2] + ((k % 2 == 1) ? 12'd4 : 12'd0), 32'h0);
      checkOutputs("R2 R3 zero mask");
    end
    checkReads("R8 final");

    // R7 div13 bit as a plain bit
    busWrite(12'h084, 32'h8000_0000);
    check("R7 div13 low", {63'h0, uartDiv13}, 64'h0);
    busWrite(12'h080, 32'h8000_0000);
    check("R7 div13 high", {63'h0, uartDiv13}, 64'h1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule